// File: doc/BRIEF.md
# Nine-bit multiprocessor UART

This block is a byte-wide, register-mapped asynchronous serial port. Software configures it through a control register and moves characters through a data location. Writing the data location hands a byte to the serial transmitter, and reading it returns the last accepted received byte. The transmit path and the receive path keep separate buffers behind the same address. Frames are either ten bits long (start, eight data bits LSB first, stop) or eleven bits long, with a ninth data bit inserted before the stop bit.

In the eleven-bit format the block supports multidrop addressing. When filtering is switched on, a received frame whose ninth bit is 0 is thrown away without disturbing software. A frame whose ninth bit is 1 is delivered as an address character. Bit timing comes from one of two externally supplied baud ticks, each running at sixteen times the bit rate, and a control bit selects between them. Two sticky completion flags, one for transmit and one for receive, are ORed into a single interrupt line. Software clears each flag by writing 0 to it.

Top module: `mpuart`

## Requirements
- R1: After reset the control register reads 0x00, the data location reads 0x00, `txd` is high and `irq` is low.
- R2: The control register is at bus address 0xAC. Its bits are: bit7 frame length (1 = eleven-bit), bit6 tick source, bit5 address filter enable, bit4 receive enable, bit3 outgoing ninth bit, bit2 incoming ninth bit, bit1 transmit flag, bit0 receive flag. The data location is at 0xAD. A write there starts a transmission, and a read returns the receive buffer, never the byte last written.
- R3: With bit7 = 0 the transmitter sends a low start bit, then the eight data bits LSB first, then a high stop bit. Each bit lasts 16 ticks of the selected source.
- R4: With bit7 = 1 the transmitter sends control bit3 as a ninth bit between the last data bit and the stop bit.
- R5: Control bit6 = 0 times the serial bits from `baud_tick_a`, and bit6 = 1 times them from `baud_tick_b`.
- R6: The transmit flag (bit1) is still 0 during the final data or ninth bit and is set when the stop bit starts being driven.
- R7: A received frame is written to the receive buffer and sets the receive flag (bit0) at the middle of its stop bit. The flag is still 0 early in the stop bit.
- R8: In eleven-bit mode the received ninth bit is stored into control bit2.
- R9: With bit7 = 1, bit5 = 1 and bit4 = 1, a frame whose ninth bit is 0 leaves the receive buffer and the receive flag unchanged, while a frame whose ninth bit is 1 is accepted. With bit7 = 0 the filter bit has no effect.
- R10: With bit4 = 0 the receiver ignores the line: no frame is accepted and the buffer keeps its value.
- R11: A low pulse on `rxd` that is high again at the middle of the start bit is rejected as noise and produces no frame. The receiver then stays ready for the next real frame.
- R12: Both flags hold until software writes 0 to them. Writing 1 to a flag bit leaves it unchanged. `irq` is the OR of the two flags.
- R13: A data write made while a frame is being sent is held and transmitted immediately after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| baud_tick_a | input | 1 | First oversampling tick source (16 per bit) |
| baud_tick_b | input | 1 | Second oversampling tick source (16 per bit) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt request, OR of both flags |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and the control and data locations at 0xAC and 0xAD. It drives `baud_tick_a` every second clock and `baud_tick_b` every fourth clock. A bit then lasts 32 or 64 clocks, which makes a wrong tick source show up as a misread frame, and an eleven-bit frame still fits in a few hundred cycles. The short bit time lets the bench cover every combination of frame length, filter enable and ninth-bit value. It also leaves room for back-to-back transmissions and the noise-pulse case within one short run.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    localparam int BYTE_W = 8;

    // Field order matches the software-visible bit layout, MSB first.
    typedef struct packed {
        logic mode9;
        logic baud_sel;
        logic mp_en;
        logic rx_en;
        logic tx_bit9;
        logic rx_bit9;
        logic tx_flag;
        logic rx_flag;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
    } frame_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;

    // A frame reaches software unless the address filter rejects it.
    function automatic logic frame_wanted(input logic mode9, input logic mp_en,
                                          input logic bit9);
        return !(mode9 && mp_en && !bit9);
    endfunction

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mode9,
    input  logic              bit9_in,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              txd,
    output logic              stop_begin
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shifter;
    logic [BYTE_W-1:0] pend_data;
    logic              pend_valid;
    logic              frame9;
    logic              nine;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TX_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shifter    <= '0;
            pend_data  <= '0;
            pend_valid <= 1'b0;
            frame9     <= 1'b0;
            nine       <= 1'b0;
            txd        <= 1'b1;
            stop_begin <= 1'b0;
        end else begin
            stop_begin <= 1'b0;
            if (state == TX_IDLE) begin
                if (pend_valid) begin
                    shifter    <= pend_data;
                    frame9     <= mode9;
                    nine       <= bit9_in;
                    pend_valid <= 1'b0;
                    cnt        <= '0;
                    txd        <= 1'b0;
                    state      <= TX_START;
                end
            end else if (tick) begin
                if (cnt != LAST_TICK) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    case (state)
                        TX_START: begin
                            txd     <= shifter[0];
                            shifter <= shifter >> 1;
                            bitn    <= '0;
                            state   <= TX_DATA;
                        end
                        TX_DATA: begin
                            if (bitn != LAST_BIT) begin
                                bitn    <= bitn + 1'b1;
                                txd     <= shifter[0];
                                shifter <= shifter >> 1;
                            end else if (frame9) begin
                                txd   <= nine;
                                state <= TX_NINTH;
                            end else begin
                                txd        <= 1'b1;
                                stop_begin <= 1'b1;
                                state      <= TX_STOP;
                            end
                        end
                        TX_NINTH: begin
                            txd        <= 1'b1;
                            stop_begin <= 1'b1;
                            state      <= TX_STOP;
                        end
                        default: begin
                            txd   <= 1'b1;
                            state <= TX_IDLE;
                        end
                    endcase
                end
            end
            // A new write always lands in the holding register, even mid-frame.
            if (load) begin
                pend_data  <= load_data;
                pend_valid <= 1'b1;
            end
        end
    end

    // R6: the done strobe coincides with the stop level on the line.
    assert_stop_level_R6: assert property (@(posedge clk) disable iff (rst)
        stop_begin |-> txd);

    // R3: an idle transmitter with nothing queued keeps the line high.
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && !pend_valid) |=> txd);

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rx_en,
    input  logic   mode9,
    input  logic   rxd,
    output logic   done,
    output frame_t frame
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [BYTE_W-1:0] shifter;
    logic              nine;
    logic              rx_meta;
    logic              rx_sync;
    logic              rx_prev;
    logic              at_mid;
    logic              at_end;

    assign at_mid = tick && (cnt == MID_TICK);
    assign at_end = tick && (cnt == LAST_TICK);
    assign frame  = '{data: shifter, bit9: nine};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shifter <= '0;
            nine    <= 1'b0;
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
            rx_prev <= 1'b1;
            done    <= 1'b0;
        end else begin
            done    <= 1'b0;
            rx_meta <= rxd;
            rx_sync <= rx_meta;
            rx_prev <= rx_sync;
            if (state != RX_IDLE && tick)
                cnt <= at_end ? '0 : cnt + 1'b1;
            case (state)
                RX_IDLE: begin
                    if (rx_en && rx_prev && !rx_sync) begin
                        cnt   <= '0;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (at_mid && rx_sync) begin
                        state <= RX_IDLE;
                    end else if (at_end) begin
                        bitn  <= '0;
                        state <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (at_mid)
                        shifter <= {rx_sync, shifter[BYTE_W-1:1]};
                    if (at_end) begin
                        if (bitn != LAST_BIT)
                            bitn <= bitn + 1'b1;
                        else
                            state <= mode9 ? RX_NINTH : RX_STOP;
                    end
                end
                RX_NINTH: begin
                    if (at_mid)
                        nine <= rx_sync;
                    if (at_end)
                        state <= RX_STOP;
                end
                default: begin
                    if (at_mid) begin
                        done  <= 1'b1;
                        state <= RX_IDLE;
                    end
                end
            endcase
        end
    end

    // R10: a disabled receiver never leaves idle.
    assert_disabled_stays_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && !rx_en) |=> state == RX_IDLE);

    // R7: each received frame produces a single-cycle completion strobe.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
    import mpuart_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hAC,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tx_stop_begin,
    input  logic              rx_done,
    input  frame_t            rx_frame,
    output ctrl_t             ctrl,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_load_data,
    output logic              irq
);
    logic [BYTE_W-1:0] rbuf;
    logic              wr_ctrl;
    logic              accept;

    assign wr_ctrl      = bus_wr && (bus_addr == CTRL_ADDR);
    assign tx_load      = bus_wr && (bus_addr == DATA_ADDR);
    assign tx_load_data = bus_wdata;
    assign accept       = frame_wanted(ctrl.mode9, ctrl.mp_en, rx_frame.bit9);
    assign irq          = ctrl.tx_flag | ctrl.rx_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rbuf <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_t'({bus_wdata[7:2],
                                 ctrl.tx_flag & bus_wdata[1],
                                 ctrl.rx_flag & bus_wdata[0]});
            // Hardware events win over a simultaneous software clear.
            if (tx_stop_begin)
                ctrl.tx_flag <= 1'b1;
            if (rx_done && accept) begin
                rbuf         <= rx_frame.data;
                ctrl.rx_flag <= 1'b1;
                if (ctrl.mode9)
                    ctrl.rx_bit9 <= rx_frame.bit9;
            end
        end
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR)
            bus_rdata = ctrl;
        else if (bus_addr == DATA_ADDR)
            bus_rdata = rbuf;
        else
            bus_rdata = '0;
    end

    // R12: flags only fall on an explicit software zero.
    assert_rx_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (ctrl.rx_flag && !(wr_ctrl && !bus_wdata[0])) |=> ctrl.rx_flag);
    assert_tx_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tx_flag && !(wr_ctrl && !bus_wdata[1])) |=> ctrl.tx_flag);

    // R9: a filtered frame leaves the receive buffer as it was.
    assert_filtered_keeps_buffer_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !accept) |=> $stable(rbuf));

endmodule

// File: rtl/mpuart.sv
module mpuart
    import mpuart_pkg::*;
#(
    parameter int                OVERSAMPLE = 16,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hAC,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 8'hAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              baud_tick_a,
    input  logic              baud_tick_b,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    ctrl_t             ctrl;
    frame_t            rx_frame;
    logic              tick;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_load_data;
    logic              tx_stop_begin;
    logic              rx_done;

    assign tick = ctrl.baud_sel ? baud_tick_b : baud_tick_a;

    mpuart_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_stop_begin(tx_stop_begin),
        .rx_done      (rx_done),
        .rx_frame     (rx_frame),
        .ctrl         (ctrl),
        .tx_load      (tx_load),
        .tx_load_data (tx_load_data),
        .irq          (irq)
    );

    mpuart_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode9     (ctrl.mode9),
        .bit9_in   (ctrl.tx_bit9),
        .load      (tx_load),
        .load_data (tx_load_data),
        .txd       (txd),
        .stop_begin(tx_stop_begin)
    );

    mpuart_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .rx_en(ctrl.rx_en),
        .mode9(ctrl.mode9),
        .rxd  (rxd),
        .done (rx_done),
        .frame(rx_frame)
    );

endmodule

// File: tb/mpuart_tb.sv
`timescale 1ns/1ps
module mpuart_tb;
    localparam logic [7:0] CTRL = 8'hAC;
    localparam logic [7:0] DATA = 8'hAD;
    localparam int BIT_A = 32;
    localparam int BIT_B = 64;
    // {frame9, filter, ninth bit, 0, data byte}
    localparam logic [11:0] VEC [6] = '{12'h0A5, 12'h43C, 12'h881,
                                        12'hA7E, 12'hCC3, 12'hE5A};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = CTRL;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       baud_tick_a = 1'b0;
    logic       baud_tick_b = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;
    logic [1:0] tick_cnt = '0;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tick_cnt    <= tick_cnt + 1'b1;
        baud_tick_a <= tick_cnt[0];
        baud_tick_b <= (tick_cnt == 2'd3);
    end

    mpuart u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .baud_tick_a(baud_tick_a), .baud_tick_b(baud_tick_b),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = CTRL;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
        bus_addr = CTRL;
        #0.1;
    endtask

    // Captures one transmitted frame at bit centres; bit 0 is the start bit.
    task automatic cap(input int bitc, input int nb, output logic [10:0] bits,
                       output logic pre, output logic post);
        bits = '1; pre = 1'bx; post = 1'bx;
        while (txd) @(negedge clk);
        repeat (bitc / 2) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            bits[k] = txd;
            if (k == nb - 2) pre = bus_rdata[1];
            if (k == nb - 1) post = bus_rdata[1];
            if (k < nb - 1) repeat (bitc) @(negedge clk);
        end
    endtask

    // Drives one frame on rxd; early = receive flag a few clocks into the stop bit.
    task automatic send(input int bitc, input logic m9, input logic b9,
                        input logic [7:0] d, output logic early);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitc) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = d[k];
            repeat (bitc) @(negedge clk);
        end
        if (m9) begin
            rxd = b9;
            repeat (bitc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        early = bus_rdata[0];
        repeat (bitc - 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [7:0]  model_rbuf;
        logic [10:0] bits;
        logic [10:0] exp_bits;
        logic        pre, post, early, acc;
        model_rbuf = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, v); chk("R1 ctrl", v, 8'h00);
        rd(DATA, v); chk("R1 data", v, 8'h00);
        chk("R1 txd", txd, 1'b1);
        chk("R1 irq", irq, 1'b0);

        // Table walk: transmit then receive each pattern (R2 R3 R4 R6 R7 R8 R9 R12)
        for (int i = 0; i < 6; i++) begin
            logic m9, mp, b9;
            logic [7:0] d, cfg;
            m9 = VEC[i][11]; mp = VEC[i][10]; b9 = VEC[i][9]; d = VEC[i][7:0];
            cfg = {m9, 1'b0, mp, 1'b1, b9, 3'b000};
            wr(CTRL, cfg);
            wr(DATA, d);
            cap(BIT_A, m9 ? 11 : 10, bits, pre, post);
            exp_bits = m9 ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
            chk(m9 ? "R4 frame bits" : "R3 frame bits", bits, exp_bits);
            chk("R6 flag before stop", pre, 1'b0);
            chk("R6 flag at stop", post, 1'b1);
            chk("R12 irq follows flag", irq, 1'b1);
            repeat (24) @(negedge clk);
            wr(CTRL, cfg);
            chk("R12 irq after clear", irq, 1'b0);

            send(BIT_A, m9, b9, d, early);
            acc = !(m9 && mp && !b9);
            if (acc) model_rbuf = d;
            chk("R7 flag early in stop", early, 1'b0);
            rd(CTRL, v);
            chk(acc ? "R7 flag at mid stop" : "R9 dropped frame flag", v[0], acc);
            if (m9 && acc) chk("R8 ninth bit stored", v[2], b9);
            rd(DATA, v);
            chk("R9 receive buffer", v, model_rbuf);
            wr(CTRL, cfg);
        end

        // R10: receiver disabled
        wr(CTRL, 8'h00);
        send(BIT_A, 1'b0, 1'b0, 8'h99, early);
        repeat (40) @(negedge clk);
        rd(CTRL, v); chk("R10 no flag when disabled", v[0], 1'b0);
        rd(DATA, v); chk("R10 buffer kept", v, model_rbuf);

        // R11: short low pulse rejected, then a real frame is received
        wr(CTRL, 8'h10);
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        rd(CTRL, v); chk("R11 glitch no flag", v[0], 1'b0);
        rd(DATA, v); chk("R11 glitch buffer kept", v, model_rbuf);
        send(BIT_A, 1'b0, 1'b0, 8'h66, early);
        model_rbuf = 8'h66;
        rd(DATA, v); chk("R11 frame after glitch", v, 8'h66);
        rd(CTRL, v); chk("R11 flag after glitch", v[0], 1'b1);
        wr(CTRL, 8'h10);

        // R5: second tick source gives a 64-clock bit
        wr(CTRL, 8'h40);
        wr(DATA, 8'h2D);
        cap(BIT_B, 10, bits, pre, post);
        chk("R5 slow source frame", bits, {2'b11, 8'h2D, 1'b0});
        repeat (40) @(negedge clk);

        // R13: second write during a frame is queued
        wr(CTRL, 8'h00);
        wr(DATA, 8'h11);
        wr(DATA, 8'h22);
        cap(BIT_A, 10, bits, pre, post);
        chk("R13 first frame", bits, {2'b11, 8'h11, 1'b0});
        cap(BIT_A, 10, bits, pre, post);
        chk("R13 queued frame", bits, {2'b11, 8'h22, 1'b0});
        repeat (24) @(negedge clk);

        // R2: data read returns the receive buffer, not the written byte
        rd(DATA, v); chk("R2 separate buffers", v, model_rbuf);

        // R12: writing 1 keeps the flag, writing 0 clears it
        wr(CTRL, 8'h02);
        rd(CTRL, v); chk("R12 write one keeps flag", v[1], 1'b1);
        chk("R12 irq held", irq, 1'b1);
        wr(CTRL, 8'h00);
        rd(CTRL, v); chk("R12 write zero clears", v[1], 1'b0);
        chk("R12 irq low", irq, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule